// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register File

This block is the byte-wide register file that sits behind a real-time clock. A host reaches it through two ports. A write to the index port chooses a location. A write or read on the data port then moves a byte to or from that location. The file holds the time and alarm bytes, four control/status registers (A at 0x0A, B at 0x0B, C at 0x0C, D at 0x0D) and general storage bytes. Its depth is 64 or 128 locations, chosen by a parameter.

Register C gathers event flags that the neighbouring time-base and rate blocks raise through a four-bit flag-set input. Reading C clears it. An interrupt line follows C's top bit. The register file drives the current rate field of A and the periodic-enable bit of B to the rate generator. It also sends a one-cycle pulse whenever either of those values changes, so the generator can re-evaluate.

There are two resets. The power-on reset loads the defaults. The system reset applies the partial clearing rules and leaves A and D alone.

Top module: `rtc_index_regs`

## Requirements
- R1: A write with `busSel`=0 latches the low log2(NUM_REGS) bits of `busWdata` as the index (0x8C becomes 0x0C at depth 128). A read with `busSel`=0 returns the index, zero-extended, on `busRdata` one cycle later.
- R2: A read with `busSel`=1 (and `busWr`=0) places the indexed byte on `busRdata` one clock after the read cycle. `busRdata` holds its value until the next read.
- R3: A data read while the index is 0x0C returns C's old value and clears C at the same edge. Flags raised in that same cycle survive: C becomes {cFlagSet,4'b0000}.
- R4: A data write to B stores the byte with bit 3 forced to 0. If bit 7 of the written byte is 1, bit 4 is also forced to 0.
- R5: A data write to A stores bits 6..0 of the byte and forces bit 7 to 0.
- R6: Data writes to C (0x0C) and D (0x0D) leave those registers unchanged.
- R7: A cycle with `rstN`=0 (and `porN`=1) sets the index to 0, ANDs B with 0x8F, clears C and `busRdata`, and leaves A and D unchanged.
- R8: A cycle with `porN`=0 clears every location and the index, then loads A=0x26, B=0x02, C=0x00 and D=0x80.
- R9: `rateSel` shows A[3:0] and `periodicEn` shows B[6]. `rateChange` is high for exactly the one cycle that follows any clock edge at which either of them changed.
- R10: `irq` equals C bit 7. `cFlagSet[3:0]` ORs into C bits 7..4 at the next edge.
- R11: A data write to any location other than A, B, C or D stores the full byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Synchronous power-on reset, active low; loads defaults |
| rstN | input | 1 | Synchronous system reset, active low; partial clearing |
| busWr | input | 1 | Write strobe for the selected port |
| busRd | input | 1 | Read strobe for the selected port; ignored when busWr is high |
| busSel | input | 1 | 0 = index port, 1 = data port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| cFlagSet | input | 4 | Flag-set requests ORed into C bits 7..4 |
| irq | output | 1 | Interrupt request, equal to C bit 7 |
| rateSel | output | 4 | Rate field of register A |
| periodicEn | output | 1 | Periodic enable, bit 6 of register B |
| rateChange | output | 1 | One-cycle pulse after rateSel or periodicEn changes |

## Verification
Every result of this block is due one clock after the cycle that causes it:
- read data, the cleared or set C, the masked A and B contents and the index all appear after that edge;
- `irq`, `rateSel` and `periodicEn` follow at the same time;
- `rateChange` is high in exactly the cycle after the edge that altered the rate field or the enable bit.

The bench drives inputs at the falling edge. A behavioural model advances at each rising edge and is compared with every output at the following falling edge. Directed reads are taken at the falling edge after the read cycle, which is the first moment the registered read data is valid.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;
  // Control/status locations; fixed because software decodes them
  localparam int unsigned ADDR_A = 10;
  localparam int unsigned ADDR_B = 11;
  localparam int unsigned ADDR_C = 12;
  localparam int unsigned ADDR_D = 13;

  localparam logic [7:0] DEF_A = 8'h26;
  localparam logic [7:0] DEF_B = 8'h02;
  localparam logic [7:0] DEF_C = 8'h00;
  localparam logic [7:0] DEF_D = 8'h80;

  // System reset keeps B bits 7 and 3..0
  localparam logic [7:0] RST_KEEP_B = 8'h8F;

  typedef struct packed {
    logic idxWr;    // latch new index
    logic plainWr;  // store full byte at index
    logic aWr;      // store into register A
    logic bWr;      // store into register B
    logic dataRd;   // capture indexed byte
    logic idxRd;    // capture index value
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_idx_ctrl.sv
module rtc_idx_ctrl
  import rtc_idx_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             busWr,
  input  logic             busRd,
  input  logic             busSel,
  input  logic [IDX_W-1:0] curIdx,
  output rtcStrobe_t       strb
);
  logic dataWrite;
  logic hitA;
  logic hitB;
  logic hitRo;
  logic readGo;

  assign hitA      = (curIdx == IDX_W'(ADDR_A));
  assign hitB      = (curIdx == IDX_W'(ADDR_B));
  assign hitRo     = (curIdx == IDX_W'(ADDR_C)) || (curIdx == IDX_W'(ADDR_D));
  assign dataWrite = busWr && busSel;
  assign readGo    = busRd && !busWr;

  always_comb begin
    strb         = '0;
    strb.idxWr   = busWr && !busSel;
    strb.aWr     = dataWrite && hitA;
    strb.bWr     = dataWrite && hitB;
    strb.plainWr = dataWrite && !hitA && !hitB && !hitRo;
    strb.dataRd  = readGo && busSel;
    strb.idxRd   = readGo && !busSel;
  end

  // R11
  write_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!porN)
    $onehot0({strb.idxWr, strb.plainWr, strb.aWr, strb.bWr, strb.dataRd}));

  // R6
  ro_write_blocked_chk: assert property (@(posedge clk) disable iff (!porN)
    (dataWrite && hitRo) |-> !(strb.plainWr || strb.aWr || strb.bWr));
endmodule

// File: rtl/rtc_idx_datapath.sv
module rtc_idx_datapath
  import rtc_idx_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  rtcStrobe_t       strb,
  input  logic [7:0]       wdata,
  input  logic [3:0]       cSet,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       rdata,
  output logic [7:0]       regA,
  output logic [7:0]       regB,
  output logic [7:0]       regC,
  output logic             rateChange
);
  localparam int PAD_W = 8 - IDX_W;

  logic [7:0] regs [NUM_REGS];
  logic [4:0] prevKey;
  logic [4:0] curKey;
  logic [7:0] bMasked;
  logic [7:0] regD;
  logic       cClr;

  assign regA = regs[ADDR_A];
  assign regB = regs[ADDR_B];
  assign regC = regs[ADDR_C];
  assign regD = regs[ADDR_D];

  assign curKey     = {regA[3:0], regB[6]};
  assign rateChange = (curKey != prevKey);
  assign cClr       = strb.dataRd && (idx == IDX_W'(ADDR_C));

  always_comb begin
    bMasked    = wdata;
    bMasked[3] = 1'b0;
    if (wdata[7]) bMasked[4] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!porN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'h00;
      regs[ADDR_A] <= DEF_A;
      regs[ADDR_B] <= DEF_B;
      regs[ADDR_C] <= DEF_C;
      regs[ADDR_D] <= DEF_D;
      idx     <= '0;
      rdata   <= 8'h00;
      prevKey <= {DEF_A[3:0], DEF_B[6]};
    end else begin
      prevKey <= curKey;
      if (!rstN) begin
        idx          <= '0;
        rdata        <= 8'h00;
        regs[ADDR_B] <= regB & RST_KEEP_B;
        regs[ADDR_C] <= 8'h00;
      end else begin
        if (strb.idxWr)   idx <= wdata[IDX_W-1:0];
        if (strb.plainWr) regs[idx] <= wdata;
        if (strb.aWr)     regs[ADDR_A] <= {1'b0, wdata[6:0]};
        if (strb.bWr)     regs[ADDR_B] <= bMasked;
        if (strb.dataRd)     rdata <= regs[idx];
        else if (strb.idxRd) rdata <= {{PAD_W{1'b0}}, idx};
        regs[ADDR_C] <= (cClr ? 8'h00 : regC) | {cSet, 4'b0000};
      end
    end
  end

  // R1
  idx_latch_chk: assert property (@(posedge clk) disable iff (!porN || !rstN)
    strb.idxWr |=> idx == $past(wdata[IDX_W-1:0]));

  // R3
  c_clear_on_read_chk: assert property (@(posedge clk) disable iff (!porN || !rstN)
    cClr |=> regC == {$past(cSet), 4'b0000});

  // R5
  a_top_bit_chk: assert property (@(posedge clk) disable iff (!porN || !rstN)
    strb.aWr |=> (regA[7] == 1'b0) && (regA[6:0] == $past(wdata[6:0])));

  // R4
  b_mask_chk: assert property (@(posedge clk) disable iff (!porN || !rstN)
    strb.bWr |=> !regB[3] && !(regB[7] && regB[4]));

  // R6
  d_stable_chk: assert property (@(posedge clk) disable iff (!porN)
    porN |=> $stable(regD));

  // R7
  sys_reset_chk: assert property (@(posedge clk) disable iff (!porN)
    !rstN |=> (idx == '0) && (regC == 8'h00) && (regB[6:4] == 3'b000));
endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
  import rtc_idx_pkg::*;
#(
  parameter int NUM_REGS = 128
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       busSel,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic [3:0] cFlagSet,
  output logic       irq,
  output logic [3:0] rateSel,
  output logic       periodicEn,
  output logic       rateChange
);
  localparam int IDX_W = $clog2(NUM_REGS);

  rtcStrobe_t       strb;
  logic [IDX_W-1:0] curIdx;
  logic [7:0]       regA;
  logic [7:0]       regB;
  logic [7:0]       regC;

  rtc_idx_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk    (clk),
    .porN   (porN),
    .busWr  (busWr),
    .busRd  (busRd),
    .busSel (busSel),
    .curIdx (curIdx),
    .strb   (strb)
  );

  rtc_idx_datapath #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) uData (
    .clk        (clk),
    .porN       (porN),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (busWdata),
    .cSet       (cFlagSet),
    .idx        (curIdx),
    .rdata      (busRdata),
    .regA       (regA),
    .regB       (regB),
    .regC       (regC),
    .rateChange (rateChange)
  );

  assign irq        = regC[7];
  assign rateSel    = regA[3:0];
  assign periodicEn = regB[6];

  // R10
  irq_clears_chk: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (strb.dataRd && curIdx == IDX_W'(ADDR_C) && !cFlagSet[3]) |=> !irq);
endmodule

// File: tb/rtc_index_regs_test.sv
module rtc_index_regs_test;
  localparam int N = 128;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic       busSel = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [3:0] cFlagSet = 4'h0;
  logic [7:0] busRdata;
  logic       irq;
  logic [3:0] rateSel;
  logic       periodicEn;
  logic       rateChange;

  int checks = 0;
  int fails = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int mem [N];
  int mIdx = 0;
  int mRd = 0;
  int mRc = 0;
  int oldKey;
  int cNext;
  int bVal;

  always #10 clk = ~clk;

  rtc_index_regs #(.NUM_REGS(N)) uut (
    .clk(clk), .porN(porN), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busSel(busSel), .busWdata(busWdata), .busRdata(busRdata),
    .cFlagSet(cFlagSet), .irq(irq), .rateSel(rateSel),
    .periodicEn(periodicEn), .rateChange(rateChange)
  );

  function automatic int keyOf();
    return ((mem[10] & 15) << 1) | ((mem[11] >> 6) & 1);
  endfunction

  always @(posedge clk) begin
    oldKey = keyOf();
    if (!porN) begin
      foreach (mem[i]) mem[i] = 0;
      mem[10] = 'h26; mem[11] = 'h02; mem[12] = 'h00; mem[13] = 'h80;
      mIdx = 0; mRd = 0;
      oldKey = keyOf();
    end else if (!rstN) begin
      mIdx = 0; mRd = 0;
      mem[11] = mem[11] & 'h8F;
      mem[12] = 0;
    end else begin
      cNext = mem[12];
      if (busWr) begin
        if (!busSel) mIdx = int'(busWdata) % N;
        else if (mIdx == 10) mem[10] = int'(busWdata) & 'h7F;
        else if (mIdx == 11) begin
          bVal = int'(busWdata) & 'hF7;
          if ((bVal & 'h80) != 0) bVal = bVal & 'hEF;
          mem[11] = bVal;
        end else if (mIdx != 12 && mIdx != 13) mem[mIdx] = int'(busWdata);
      end else if (busRd) begin
        if (busSel) begin
          mRd = mem[mIdx];
          if (mIdx == 12) cNext = 0;
        end else mRd = mIdx;
      end
      mem[12] = cNext | (int'(cFlagSet) << 4);
    end
    mRc = (keyOf() != oldKey) ? 1 : 0;
    started = 1'b1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 busRdata", int'(busRdata), mRd);
      chk("R10 irq", int'(irq), (mem[12] >> 7) & 1);
      chk("R9 rateSel", int'(rateSel), mem[10] & 15);
      chk("R9 periodicEn", int'(periodicEn), (mem[11] >> 6) & 1);
      chk("R9 rateChange", int'(rateChange), mRc);
    end
  end

  task automatic cyc(bit wr, bit rd, bit sel, logic [7:0] d, logic [3:0] f);
    @(negedge clk);
    busWr = wr; busRd = rd; busSel = sel; busWdata = d; cFlagSet = f;
    @(negedge clk);
    busWr = 0; busRd = 0; cFlagSet = 4'h0;
  endtask

  task automatic wrIdx(logic [7:0] v);
    cyc(1, 0, 0, v, 4'h0);
  endtask

  task automatic wrData(logic [7:0] v);
    cyc(1, 0, 1, v, 4'h0);
  endtask

  task automatic rdReg(logic [7:0] a, output int v);
    wrIdx(a);
    cyc(0, 1, 1, 8'h00, 4'h0);
    v = int'(busRdata);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    int v;
    repeat (2) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    // R8 power-up defaults
    rdReg(8'h0A, v); chk("R8 A default", v, 'h26);
    rdReg(8'h0B, v); chk("R8 B default", v, 'h02);
    rdReg(8'h0C, v); chk("R8 C default", v, 'h00);
    rdReg(8'h0D, v); chk("R8 D default", v, 'h80);
    // R1 index masking and index read
    wrIdx(8'h8C);
    cyc(0, 1, 0, 8'h00, 4'h0);
    chk("R1 index read", int'(busRdata), 'h0C);
    // R11 plain storage, R2 read back
    wrIdx(8'h20); wrData(8'h5A);
    wrIdx(8'h00); wrData(8'h59);
    rdReg(8'h20, v); chk("R11 byte 0x20", v, 'h5A);
    rdReg(8'h00, v); chk("R2 byte 0x00", v, 'h59);
    // R5 A top bit, R9 pulse
    wrIdx(8'h0A); wrData(8'hA3);
    chk("R9 pulse on rate change", int'(rateChange), 1);
    chk("R9 rateSel", int'(rateSel), 3);
    wrData(8'h23);
    chk("R9 no pulse same rate", int'(rateChange), 0);
    rdReg(8'h0A, v); chk("R5 A write", v, 'h23);
    // R4 B masking
    wrIdx(8'h0B); wrData(8'hFA);
    rdReg(8'h0B, v); chk("R4 B set-mode", v, 'hE2);
    wrIdx(8'h0B); wrData(8'h5E);
    rdReg(8'h0B, v); chk("R4 B bit3", v, 'h56);
    chk("R9 periodicEn", int'(periodicEn), 1);
    // R6 read-only C and D
    wrIdx(8'h0D); wrData(8'h00);
    rdReg(8'h0D, v); chk("R6 D unchanged", v, 'h80);
    wrIdx(8'h0C); wrData(8'hFF);
    rdReg(8'h0C, v); chk("R6 C unchanged", v, 'h00);
    // R10 / R3 flags and clear on read
    cyc(0, 0, 0, 8'h00, 4'b1100);
    chk("R10 irq set", int'(irq), 1);
    rdReg(8'h0C, v); chk("R3 C read", v, 'hC0);
    chk("R10 irq cleared", int'(irq), 0);
    rdReg(8'h0C, v); chk("R3 C cleared", v, 'h00);
    cyc(0, 0, 0, 8'h00, 4'b0010);
    wrIdx(8'h0C);
    cyc(0, 1, 1, 8'h00, 4'b1000);
    chk("R3 coincide old value", int'(busRdata), 'h20);
    chk("R3 set wins irq", int'(irq), 1);
    cyc(0, 1, 1, 8'h00, 4'h0);
    chk("R3 set wins value", int'(busRdata), 'h80);
    // R7 system reset
    wrIdx(8'h0C);
    cyc(0, 0, 0, 8'h00, 4'b1000);
    wrIdx(8'h21);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R7 irq cleared", int'(irq), 0);
    chk("R7 pulse on enable drop", int'(rateChange), 1);
    cyc(0, 1, 0, 8'h00, 4'h0);
    chk("R7 index zero", int'(busRdata), 0);
    rdReg(8'h0B, v); chk("R7 B masked", v, 'h06);
    rdReg(8'h0A, v); chk("R7 A kept", v, 'h23);
    rdReg(8'h0D, v); chk("R7 D kept", v, 'h80);
    rdReg(8'h20, v); chk("R7 storage kept", v, 'h5A);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule